// File: doc/BRIEF.md
# Streaming Modular Polynomial Subtractor

This block computes, coefficient by coefficient, the difference of two 256-entry polynomials modulo 3329. The minuend polynomial sits in one memory bank and the subtrahend in a second bank. Each bank has a single read port, so the block can read both operands in the same cycle by giving each bank its own read-address output. After a start pulse the block walks the coefficient indices in ascending order, one new index per cycle. Each bank returns its data one cycle after the address. The block pairs that data with a delayed copy of the index and writes the reduced difference back over the subtrahend, at the same index.

It sits between an earlier stage that leaves the subtrahend polynomial in its bank and a later stage that consumes the result in place. Both operand values must already lie in [0, 3328]. With that assumption one conditional correction by the modulus is enough.

Top module: `polysub_stream`

## Requirements
- R1: While reset is held and in the first cycle after it is released with no start, the write enable and the done flag are both low.
- R2: For operands a and b in [0, 3328], each written value equals (a − b) mod 3329 and is always below 3329. A difference that would be negative is corrected by adding 3329. This includes a = b giving 0, a = 0 with b = 3328 giving 1, and a = 3328 with b = 0 giving 3328.
- R3: In the cycle after the start edge, both read addresses show index 0. Both read addresses are equal and rise by exactly one per cycle up to 255.
- R4: The write for index i is presented exactly one cycle after index i was presented on the read addresses, with the write address equal to i. The write targets the subtrahend's bank, in place.
- R5: A run produces exactly 256 writes, with indices in ascending order 0 to 255. No write occurs once the run has ended.
- R6: Done goes high in the cycle after the one in which the write for index 255 is presented. It stays high until the next start pulse, and a start pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| rd_addr_a_o | output | 8 | Read address into the minuend bank |
| rd_addr_b_o | output | 8 | Read address into the subtrahend bank |
| rd_data_a_i | input | 12 | Minuend coefficient, valid one cycle after its address |
| rd_data_b_i | input | 12 | Subtrahend coefficient, valid one cycle after its address |
| wr_en_o | output | 1 | Write strobe into the subtrahend bank |
| wr_addr_o | output | 8 | Write index into the subtrahend bank |
| wr_data_o | output | 12 | Reduced difference to store |
| done_o | output | 1 | High from the cycle after the last write until the next start |

## Verification
Suppose the address counter and the delayed write index drift apart by one cycle. Then the very first write carries a value that belongs to a different index, and the per-write comparison flags it one cycle after the first address. A wrong borrow correction shows as a value that is 3329 too large or wraps. The directed corner pairs at the start of each run expose it at once. A wrong end-of-run count shows either as a 257th write or as a missing one, or as done rising one cycle early or late. Both are checked at the exact cycle. A final sweep of the subtrahend bank confirms that the results landed in place.

// File: rtl/polysub_pkg.sv
// Shared constants and types for the streaming modular subtractor.
// Assumes a single fixed modulus and coefficient width across the block.
package polysub_pkg;
    localparam int COEF_W  = 12;
    localparam int MOD_Q   = 3329;
    localparam int N_DEF   = 256;
    typedef logic [COEF_W-1:0] coef_t;
endpackage

// File: rtl/polysub_seq.sv
// Index sequencer: issues one read index per cycle after start, keeps a
// one-cycle-delayed valid/index pair for the writeback, and raises done one
// cycle after the final write is presented. Assumes banks with one-cycle read latency.
module polysub_seq #(
    parameter int N_COEF = polysub_pkg::N_DEF,
    localparam int IDX_W = $clog2(N_COEF),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             wb_valid_o,
    output logic [IDX_W-1:0] wb_idx_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             issue;

    assign issue    = busy_q && (cnt_q < CNT_W'(N_COEF));
    assign rd_idx_o = cnt_q[IDX_W-1:0];

    // Advance the read index, delay valid/index by one cycle, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            busy_q     <= 1'b0;
            wb_valid_o <= 1'b0;
            wb_idx_o   <= '0;
            done_o     <= 1'b0;
        end else if (start_i) begin
            cnt_q      <= '0;
            busy_q     <= 1'b1;
            wb_valid_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            wb_valid_o <= issue;
            if (issue) begin
                wb_idx_o <= cnt_q[IDX_W-1:0];
                cnt_q    <= cnt_q + 1'b1;
            end
            if (busy_q && cnt_q == CNT_W'(N_COEF)) begin
                busy_q <= 1'b0;
                done_o <= 1'b1;
            end
        end
    end

    // R3: consecutive issued indices step by exactly one
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !start_i && cnt_q < CNT_W'(N_COEF - 1)) |=>
            (issue && rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1)));

    // R5: no writeback strobe while done is held
    assert_no_write_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wb_valid_o);
endmodule

// File: rtl/polysub_alu.sv
// Modular subtract: (a - b) mod Q with a borrow-driven single correction.
// Assumes both operands already lie in [0, Q-1].
module polysub_alu #(
    parameter int W = polysub_pkg::COEF_W,
    parameter int Q = polysub_pkg::MOD_Q
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chk_en_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    logic [W:0] diff;

    // Form the widened difference and add Q back when it borrowed.
    always_comb begin
        diff = {1'b0, a_i} - {1'b0, b_i};
        y_o  = diff[W] ? (diff[W-1:0] + W'(Q)) : diff[W-1:0];
    end

    // R2: every written result is fully reduced
    assert_result_reduced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_i |-> (y_o < W'(Q)));
endmodule

// File: rtl/polysub_stream.sv
// Top: streams a 256-coefficient polynomial subtract across two single-port
// banks, reading both at the same index and writing the result in place into
// the subtrahend bank. Assumes one-cycle read latency and reduced operands.
module polysub_stream #(
    parameter int N_COEF = polysub_pkg::N_DEF,
    parameter int COEF_W = polysub_pkg::COEF_W,
    parameter int MOD_Q  = polysub_pkg::MOD_Q,
    localparam int IDX_W = $clog2(N_COEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [IDX_W-1:0]  rd_addr_a_o,
    output logic [IDX_W-1:0]  rd_addr_b_o,
    input  logic [COEF_W-1:0] rd_data_a_i,
    input  logic [COEF_W-1:0] rd_data_b_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_addr_o,
    output logic [COEF_W-1:0] wr_data_o,
    output logic              done_o
);
    logic [IDX_W-1:0] rd_idx;
    logic             wb_valid;
    logic [IDX_W-1:0] wb_idx;

    polysub_seq #(.N_COEF(N_COEF)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rd_idx_o   (rd_idx),
        .wb_valid_o (wb_valid),
        .wb_idx_o   (wb_idx),
        .done_o     (done_o)
    );

    polysub_alu #(.W(COEF_W), .Q(MOD_Q)) u_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en_i (wb_valid),
        .a_i      (rd_data_a_i),
        .b_i      (rd_data_b_i),
        .y_o      (wr_data_o)
    );

    // Same index to both banks; write strobe and index come from the delay stage.
    assign rd_addr_a_o = rd_idx;
    assign rd_addr_b_o = rd_idx;
    assign wr_en_o     = wb_valid;
    assign wr_addr_o   = wb_idx;

    // R4: a write follows each issued read after one cycle, at the same index
    assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o == $past(rd_addr_b_o)));

    // R6: done follows the final write by one cycle
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o == IDX_W'(N_COEF - 1) && !start_i) |=> done_o);

    // R1: nothing is written or flagged during reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!wr_en_o && !done_o));
endmodule

// File: tb/polysub_stream_bench.sv
module polysub_stream_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 256;
    localparam int Q = 3329;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [11:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en, done;

    logic [11:0] mem_a [N];
    logic [11:0] mem_b [N];
    logic [11:0] orig_b [N];

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    polysub_stream u_polysub_stream (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_addr_a_o(rd_addr_a), .rd_addr_b_o(rd_addr_b),
        .rd_data_a_i(rd_data_a), .rd_data_b_i(rd_data_b),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .done_o(done)
    );

    // Bank models: registered read, write at the clock edge.
    always @(posedge clk) begin
        rd_data_a <= mem_a[rd_addr_a];
        rd_data_b <= mem_b[rd_addr_b];
        if (wr_en) mem_b[wr_addr] <= wr_data;
    end

    function automatic int model_sub(int a, int b);
        return (a >= b) ? (a - b) : (a + Q - b);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(int mode);
        for (int i = 0; i < N; i++) begin
            int av = $urandom_range(Q - 1, 0);
            int bv = $urandom_range(Q - 1, 0);
            if (mode == 1 && (i % 4) == 0) bv = av;
            if (mode == 2) begin
                av = (i % 2) ? Q - 1 : 0;
                bv = (i % 3 == 0) ? Q - 1 : 0;
            end
            mem_a[i] = 12'(av);
            mem_b[i] = 12'(bv);
        end
        // directed corners
        mem_a[0] = 12'd1234;  mem_b[0] = 12'd1234;   // a = b -> 0
        mem_a[1] = 12'd0;     mem_b[1] = 12'(Q - 1); // -> 1
        mem_a[2] = 12'(Q - 1); mem_b[2] = 12'd0;     // -> Q-1
        for (int i = 0; i < N; i++) orig_b[i] = mem_b[i];
    endtask

    task automatic run(int mode);
        load(mode);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done == 1'b0, "R6 done cleared by start", int'(done), 0);
        for (int k = 0; k <= 257; k++) begin
            if (k < N) begin
                check(rd_addr_a == 8'(k) && rd_addr_b == 8'(k), "R3 read address",
                      int'(rd_addr_a), k);
            end
            if (k == 0) check(wr_en == 1'b0, "R4 no write before data", int'(wr_en), 0);
            if (k >= 1 && k <= N) begin
                int e = model_sub(int'(mem_a[k-1]), int'(orig_b[k-1]));
                check(wr_en == 1'b1, "R5 write strobe", int'(wr_en), 1);
                check(wr_addr == 8'(k - 1), "R4 write index", int'(wr_addr), k - 1);
                check(int'(wr_data) == e, "R2 difference", int'(wr_data), e);
            end
            if (k == N) check(done == 1'b0, "R6 done not early", int'(done), 0);
            if (k == N + 1) begin
                check(done == 1'b1, "R6 done after last write", int'(done), 1);
                check(wr_en == 1'b0, "R5 no extra write", int'(wr_en), 0);
            end
            @(negedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            check(wr_en == 1'b0 && done == 1'b1, "R5/R6 idle after run", int'(wr_en), 0);
            @(negedge clk);
        end
        for (int i = 0; i < N; i++) begin
            int e = model_sub(int'(mem_a[i]), int'(orig_b[i]));
            check(int'(mem_b[i]) == e, "R4 in-place result", int'(mem_b[i]), e);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < N; i++) begin
            mem_a[i] = '0;
            mem_b[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0, "R1 reset state", int'(wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0, "R1 idle after reset", int'(done), 0);
        run(0);
        run(1);
        run(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule